// File: doc/BRIEF.md
# Asynchronous Serial Interface Character Sequencer

This block sits in front of an 8b/10b serialiser. It decides, once per character clock, whether a 10-bit character reaches the serialiser as valid data. In transport-stream (ASI) mode, each character is taken from a FIFO-style source. The source asks for the character in one of two ways:

- an immediate request, which takes the word present at the same edge;
- a look-ahead request, which takes the word present at the following edge.

Together these let the block read from either a clocked FIFO or one with a registered empty flag. When no character is granted, the valid strobe is deasserted and the serialiser pads the link with comma characters.

The MSB of the word carries a violation flag and the LSB carries a control-character flag. Each flag has its own pass enable; a flag that is not passed is driven low. The eight bits between them pass through unchanged. A control word with the control flag set and passed can stand in for padding as an alternative way to insert fill.

When the mode input is high, the block is in video mode. The strobe is then held valid and the output follows a separate video-encoder word. All outputs come from registers, with one clock of latency.

Top module: `asi_seq_ctrl`

## Requirements
- R1: Synchronous active-high reset drives `dout` to 0 and `dvalid_n` high, and it discards any look-ahead request. A look-ahead request given before reset does not produce a character after reset.
- R2: In ASI mode (`asi_sel_n`=0), `take_now_n`=0 at an edge grants that edge's `din`. After the edge, `dvalid_n`=0 and `dout` holds the gated word.
- R3: In ASI mode, `take_next_n`=0 at edge k grants the `din` present at edge k+1, independent of `take_now_n` at k+1. The output shows the word after edge k+1, and edge k alone grants nothing.
- R4: When an ASI-mode edge has no grant, `dvalid_n` goes high and `dout` keeps its previous value.
- R5: On a granted word, `dout[9]` equals `din[9]` when `viol_pass`=1 and is 0 when `viol_pass`=0.
- R6: On a granted word, `dout[0]` equals `din[0]` when `kflag_pass`=1 and is 0 otherwise. For example, the fill code word 10'h00B (byte 8'h05 in bits 8:1, control flag in bit 0) reaches `dout` intact when `kflag_pass`=1.
- R7: On a granted word, `dout[8:1]` equals `din[8:1]`.
- R8: If an immediate request and a pending look-ahead request fall on the same edge, exactly one character is emitted on that edge. The next edge with no request grants nothing.
- R9: In video mode (`asi_sel_n`=1), `dvalid_n`=0 and `dout` equals `vid_din` after each edge, and both request inputs are ignored. A look-ahead request made in video mode does not grant on the first ASI-mode edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| asi_sel_n | input | 1 | Mode select: 0 = ASI, 1 = video |
| take_now_n | input | 1 | Immediate request, active low |
| take_next_n | input | 1 | Look-ahead request, active low |
| viol_pass | input | 1 | Pass the violation flag (bit 9) |
| kflag_pass | input | 1 | Pass the control-character flag (bit 0) |
| din | input | 10 | ASI character input |
| vid_din | input | 10 | Encoded video word from the video path |
| dout | output | 10 | Registered character to the serialiser |
| dvalid_n | output | 1 | Valid strobe, active low; high requests comma fill |

## Verification
The look-ahead grant and an immediate request can land on the same edge. To provoke this, the bench raises both requests together on one edge and then drives only an immediate request on the next edge. It then checks that one word per edge comes out and that the edge after that goes idle with the last word held.

The other collision is a mode change while a look-ahead request is outstanding. The bench judges it by whether an unwanted character appears on the first ASI-mode edge.

// File: rtl/asi_pkg.sv
package asi_pkg;
  localparam int unsigned CHAR_W = 10;
  typedef logic [CHAR_W-1:0] char_t;
  typedef enum logic {
    MODE_ASI   = 1'b0,
    MODE_VIDEO = 1'b1
  } mode_e;
endpackage

// File: rtl/asi_enable_track.sv
module asi_enable_track (
  input  logic clk,
  input  logic rst,
  input  logic asi_on,
  input  logic now_req,
  input  logic next_req,
  output logic grant
);
  logic pend_q;

  // Look-ahead request is remembered for exactly one edge.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= asi_on & next_req;
  end

  assign grant = asi_on & (now_req | pend_q);
endmodule

// File: rtl/asi_flag_gate.sv
module asi_flag_gate #(
  parameter int unsigned W       = 10,
  parameter bit          GATE_LO = 1'b1,
  parameter bit          GATE_HI = 1'b1
) (
  input  logic [W-1:0] din,
  input  logic         lo_pass,
  input  logic         hi_pass,
  output logic [W-1:0] dout
);
  localparam int unsigned MID_W = W - 2;

  assign dout[W-2:1] = din[W-2:1];

  generate
    if (GATE_LO) begin : g_lo
      assign dout[0] = din[0] & lo_pass;
    end else begin : g_lo_pass
      assign dout[0] = din[0];
    end
    if (GATE_HI) begin : g_hi
      assign dout[W-1] = din[W-1] & hi_pass;
    end else begin : g_hi_pass
      assign dout[W-1] = din[W-1];
    end
  endgenerate

  initial begin
    if (MID_W < 1) $error("asi_flag_gate: W too small");
  end
endmodule

// File: rtl/asi_seq_ctrl.sv
module asi_seq_ctrl
  import asi_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         asi_sel_n,
  input  logic         take_now_n,
  input  logic         take_next_n,
  input  logic         viol_pass,
  input  logic         kflag_pass,
  input  logic [W-1:0] din,
  input  logic [W-1:0] vid_din,
  output logic [W-1:0] dout,
  output logic         dvalid_n
);
  mode_e       mode;
  logic        asi_on;
  logic        grant;
  logic [W-1:0] gated;

  assign mode   = mode_e'(asi_sel_n);
  assign asi_on = (mode == MODE_ASI);

  asi_enable_track u_track (
    .clk      (clk),
    .rst      (rst),
    .asi_on   (asi_on),
    .now_req  (~take_now_n),
    .next_req (~take_next_n),
    .grant    (grant)
  );

  asi_flag_gate #(.W(W), .GATE_LO(1'b1), .GATE_HI(1'b1)) u_gate (
    .din     (din),
    .lo_pass (kflag_pass),
    .hi_pass (viol_pass),
    .dout    (gated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dvalid_n <= 1'b1;
    end else if (!asi_on) begin
      dout     <= vid_din;
      dvalid_n <= 1'b0;
    end else if (grant) begin
      dout     <= gated;
      dvalid_n <= 1'b0;
    end else begin
      dvalid_n <= 1'b1;
    end
  end
endmodule

// File: rtl/asi_seq_ctrl_chk.sv
module asi_seq_ctrl_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         asi_sel_n,
  input logic         take_now_n,
  input logic         take_next_n,
  input logic         viol_pass,
  input logic         kflag_pass,
  input logic [W-1:0] din,
  input logic [W-1:0] vid_din,
  input logic [W-1:0] dout,
  input logic         dvalid_n
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (dvalid_n && dout == '0));

  assert_now_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (!asi_sel_n && !take_now_n) |=> !dvalid_n);

  assert_next_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (!asi_sel_n && !$past(rst) && $past(!asi_sel_n && !take_next_n)) |=> !dvalid_n);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!asi_sel_n && take_now_n && !$past(rst) && $past(take_next_n || asi_sel_n))
      |=> (dvalid_n && $stable(dout)));

  assert_viol_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (!asi_sel_n && !take_now_n && !viol_pass) |=> !dout[W-1]);

  assert_kflag_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (!asi_sel_n && !take_now_n && !kflag_pass) |=> !dout[0]);

  assert_mid_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (!asi_sel_n && !take_now_n) |=> (dout[W-2:1] == $past(din[W-2:1])));

  assert_video_R9: assert property (@(posedge clk) disable iff (rst)
    asi_sel_n |=> (!dvalid_n && dout == $past(vid_din)));
endmodule

bind asi_seq_ctrl asi_seq_ctrl_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .asi_sel_n   (asi_sel_n),
  .take_now_n  (take_now_n),
  .take_next_n (take_next_n),
  .viol_pass   (viol_pass),
  .kflag_pass  (kflag_pass),
  .din         (din),
  .vid_din     (vid_din),
  .dout        (dout),
  .dvalid_n    (dvalid_n)
);

// File: tb/tb_asi_seq_ctrl.sv
module tb_asi_seq_ctrl;
  localparam int unsigned W = 10;

  typedef struct packed {
    logic         rst;
    logic         asi_n;
    logic         now_n;
    logic         next_n;
    logic         viol;
    logic         kflag;
    logic [W-1:0] din;
    logic [W-1:0] vid;
    logic         exp_dvn;
    logic [W-1:0] exp_q;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    // rst asi now next viol kf din      vid      dvn q        req
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,10'h3FF,10'h000,1'b0,10'h3FF,4'd2}, // R2 immediate grant
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,10'h3FF,10'h000,1'b0,10'h1FE,4'd5}, // R5 R6 R7 both flags masked
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,10'h155,10'h000,1'b1,10'h1FE,4'd4}, // R4 idle holds word
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,10'h0AA,10'h000,1'b1,10'h1FE,4'd3}, // R3 request edge grants nothing
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,10'h2C3,10'h000,1'b0,10'h2C2,4'd3}, // R3 next word taken, R6 mask
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,10'h111,10'h000,1'b1,10'h2C2,4'd4}, // R4
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,10'h00B,10'h000,1'b0,10'h00B,4'd6}, // R6 fill code word passes
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,10'h201,10'h000,1'b0,10'h201,4'd8}, // R8 coincident grants
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,10'h3FF,10'h000,1'b1,10'h201,4'd8}, // R8 no extra character
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,10'h3FF,10'h2AB,1'b0,10'h2AB,4'd9}, // R9 video word
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,10'h155,10'h000,1'b1,10'h2AB,4'd9}, // R9 video request dropped
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,10'h0F0,10'h000,1'b1,10'h2AB,4'd3}, // R3 request pending
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,10'h3FF,10'h000,1'b1,10'h000,4'd1}, // R1 reset clears
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,10'h3FF,10'h000,1'b1,10'h000,4'd1}, // R1 pending dropped
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,10'h001,10'h000,1'b1,10'h000,4'd3}, // R3
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,10'h3FE,10'h000,1'b0,10'h3FE,4'd7}, // R7 R8 single grant
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,10'h000,10'h3FF,1'b0,10'h3FF,4'd9}  // R9
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         asi_sel_n, take_now_n, take_next_n, viol_pass, kflag_pass;
  logic [W-1:0] din, vid_din, dout;
  logic         dvalid_n;
  int           n_run  = 0;
  int           n_fail = 0;
  bit           done   = 1'b0;

  always #2.5 clk = ~clk;

  asi_seq_ctrl #(.W(W)) dut (
    .clk(clk), .rst(rst), .asi_sel_n(asi_sel_n), .take_now_n(take_now_n),
    .take_next_n(take_next_n), .viol_pass(viol_pass), .kflag_pass(kflag_pass),
    .din(din), .vid_din(vid_din), .dout(dout), .dvalid_n(dvalid_n)
  );

  task automatic check(input string tag, input logic dvn_e, input logic [W-1:0] q_e);
    n_run++;
    if (dvalid_n !== dvn_e || dout !== q_e) begin
      n_fail++;
      $display("FAIL %s: dvalid_n=%b dout=%h expected dvalid_n=%b dout=%h",
               tag, dvalid_n, dout, dvn_e, q_e);
    end
  endtask

  initial begin
    rst = 1'b1; asi_sel_n = 1'b0; take_now_n = 1'b1; take_next_n = 1'b0;
    viol_pass = 1'b1; kflag_pass = 1'b1; din = '0; vid_din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 1'b1, '0);
    rst = 1'b0; take_next_n = 1'b1;
    @(negedge clk);
    check("R1 request before reset dropped", 1'b1, '0);
    for (int i = 0; i < NV; i++) begin
      rst = VEC[i].rst; asi_sel_n = VEC[i].asi_n; take_now_n = VEC[i].now_n;
      take_next_n = VEC[i].next_n; viol_pass = VEC[i].viol;
      kflag_pass = VEC[i].kflag; din = VEC[i].din; vid_din = VEC[i].vid;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_dvn, VEC[i].exp_q);
    end
    // Directed: R5 violation flag passes when enabled, R6 flag dropped
    rst = 1'b0; asi_sel_n = 1'b0; take_now_n = 1'b0; take_next_n = 1'b1;
    viol_pass = 1'b1; kflag_pass = 1'b0; din = 10'h201;
    @(negedge clk);
    check("R5 violation flag passed", 1'b0, 10'h200);
    // Directed: back-to-back look-ahead requests stream one word per edge (R3)
    take_now_n = 1'b1; take_next_n = 1'b0; din = 10'h004;
    @(negedge clk);
    check("R3 first look-ahead edge idle", 1'b1, 10'h200);
    din = 10'h008;
    @(negedge clk);
    check("R3 streaming word", 1'b0, 10'h008);
    take_next_n = 1'b1; din = 10'h010;
    @(negedge clk);
    check("R3 last streamed word", 1'b0, 10'h010);
    @(negedge clk);
    check("R4 stream ends idle", 1'b1, 10'h010);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule